// File: doc/BRIEF.md
# Moving-Inversion Memory Self-Test Controller

This block is a built-in self-test engine for one single-port synchronous memory. A one-cycle `start` pulse launches a full test. Every pass has three phases. First, a background pattern is written to every word. Next, an ascending sweep visits each word in turn: it reads the word, checks it against the background, and then overwrites it with the complement. Last, a descending sweep goes from the top address down to the bottom: it checks each word against the complement and writes the background back. When both sweeps of a pass are done, the memory again holds that pass's background.

A two-bit mode code selects which family of backgrounds the passes use:
- a solid family of all zeros and then all ones;
- a byte family of twenty 8-bit values, each copied to every byte lane;
- a rotating family in which a single one bit moves left by one position per address, and its starting position moves left by one per pass, over as many passes as the word has bits.

The first miscompare is captured with its address, expected word and observed word, and the error flag stays set. The test still runs to the end. `done` pulses when the last pass finishes.

Top module: `movinv_bist`

## Requirements
- R1: After reset, `busy`, `done`, `errFlag`, `wrEn` and `rdEn` are all 0.
- R2: Each pass starts with exactly MEM_DEPTH writes of the pass background, to addresses 0, 1, ... MEM_DEPTH-1 in that order. Over a whole test the memory port carries exactly passes × 5 × MEM_DEPTH operations.
- R3: In the ascending sweep, each address from 0 upward is read once. The returned word is compared against the background RD_LAT cycles after the read, and only after that compare is the bitwise complement of the background written to the same address. The address then increments. Reads and writes never occur in the same cycle.
- R4: The descending sweep starts at MEM_DEPTH-1 and moves down to 0. At each address it reads, compares against the complement, and writes the background back. After a fault-free test, every word holds the final pass's background.
- R5: Mode code 0 (and code 3, which behaves the same) runs 2 passes: pass 0 uses all zeros and pass 1 uses all ones.
- R6: Mode code 1 runs 20 passes, with an 8-bit value copied to every byte lane:
  - pass p < 8: 1 << p;
  - passes 8..15: the bitwise inverse of 1 << (p-8);
  - passes 16..19: 0x55, 0xAA, 0x33 and 0xCC, in that order.
- R7: Mode code 2 runs DATA_W passes. The background at address a in pass p is 1 << ((p + a) mod DATA_W).
- R8: A fill write takes 1 cycle, and each sweep location takes 2 + RD_LAT cycles. `busy` is therefore high for exactly passes × (MEM_DEPTH + 2 × MEM_DEPTH × (2 + RD_LAT)) cycles, starting the cycle after `start` is accepted.
- R9: On the first miscompare of a test, `errFlag` rises and `failAddr`, `failExp` and `failObs` capture the address, the expected word and the read word. Later miscompares change none of these, and the test still runs to completion.
- R10: `done` is high for exactly one cycle after the last write, with `busy` low. A `start` pulse while `busy` is high is ignored.
- R11: An accepted `start` clears `errFlag`, so a fault-free test that follows a failing test ends with `errFlag` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a test when idle |
| mode | input | 2 | Background family code, sampled on start |
| rdData | input | DATA_W | Memory read data, valid RD_LAT cycles after rdEn |
| memAddr | output | AW | Memory word address |
| wrData | output | DATA_W | Memory write data (expected word during the compare cycle) |
| wrEn | output | 1 | Memory write strobe |
| rdEn | output | 1 | Memory read strobe |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Sticky miscompare flag |
| failAddr | output | AW | Address of the first miscompare |
| failExp | output | DATA_W | Expected word at the first miscompare |
| failObs | output | DATA_W | Observed word at the first miscompare |

## Verification
The assertions assume three things about the environment. The memory returns the addressed word exactly RD_LAT cycles after a read strobe. `start` is only a pulse. Nothing besides an accepted `start` disturbs the captured failure record. The bench memory model therefore has a fixed one-cycle read latency, and it injects defects only as stuck-at bits on its storage path, so that the controller's own traffic on the port stays legal. A monitor compares every port operation with an independently computed order. The fault cases are drawn at random over mode, address, bit and stuck value, and each is scored against a software model of the same sweep.

// File: rtl/movinv_pkg.sv
package movinv_pkg;

  typedef enum logic [1:0] {
    PM_SOLID = 2'd0,
    PM_BYTE  = 2'd1,
    PM_ROT   = 2'd2,
    PM_ALT   = 2'd3
  } patMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WRITE,
    ST_DONE
  } ctlState_e;

  typedef struct packed {
    logic clrErr;
    logic cmpEn;
    logic invert;
  } dpStrobe_t;

  localparam int SOLID_PASSES = 2;
  localparam int BYTE_PASSES  = 20;

endpackage

// File: rtl/movinv_ctrl.sv
module movinv_ctrl
  import movinv_pkg::*;
#(
  parameter int MEM_DEPTH = 16,
  parameter int DATA_W    = 32,
  parameter int RD_LAT    = 1,
  parameter int AW        = $clog2(MEM_DEPTH),
  parameter int PW        = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    modeIn,
  output logic [AW-1:0] memAddr,
  output logic          wrEn,
  output logic          rdEn,
  output logic          busy,
  output logic          done,
  output patMode_e      modeQ,
  output logic [PW-1:0] passIdx,
  output dpStrobe_t     strb
);

  localparam int CW = $clog2(RD_LAT + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(MEM_DEPTH - 1);

  ctlState_e     state;
  logic          desc;
  logic [CW-1:0] waitCnt;
  logic [PW-1:0] lastPass;
  logic          waitDone;

  always_comb begin
    unique case (modeQ)
      PM_BYTE: lastPass = PW'(BYTE_PASSES - 1);
      PM_ROT:  lastPass = PW'(DATA_W - 1);
      default: lastPass = PW'(SOLID_PASSES - 1);
    endcase
  end

  assign waitDone = (waitCnt == CW'(RD_LAT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      memAddr <= '0;
      passIdx <= '0;
      desc    <= 1'b0;
      waitCnt <= '0;
      modeQ   <= PM_SOLID;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          modeQ   <= patMode_e'(modeIn);
          passIdx <= '0;
          memAddr <= '0;
          desc    <= 1'b0;
          state   <= ST_FILL;
        end
        ST_FILL: begin
          if (memAddr == LAST_ADDR) begin
            memAddr <= '0;
            state   <= ST_RDREQ;
          end else begin
            memAddr <= memAddr + 1'b1;
          end
        end
        ST_RDREQ: begin
          waitCnt <= CW'(1);
          state   <= ST_RDWAIT;
        end
        ST_RDWAIT: begin
          if (waitDone) state <= ST_WRITE;
          else waitCnt <= waitCnt + 1'b1;
        end
        ST_WRITE: begin
          if (!desc) begin
            if (memAddr == LAST_ADDR) desc <= 1'b1;
            else memAddr <= memAddr + 1'b1;
            state <= ST_RDREQ;
          end else if (memAddr == '0) begin
            desc <= 1'b0;
            if (passIdx == lastPass) begin
              state <= ST_DONE;
            end else begin
              passIdx <= passIdx + 1'b1;
              state   <= ST_FILL;
            end
          end else begin
            memAddr <= memAddr - 1'b1;
            state   <= ST_RDREQ;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wrEn = (state == ST_FILL) || (state == ST_WRITE);
  assign rdEn = (state == ST_RDREQ);
  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);

  assign strb.clrErr = (state == ST_IDLE) && start;
  assign strb.cmpEn  = (state == ST_RDWAIT) && waitDone;
  assign strb.invert = ((state == ST_RDWAIT) && desc) || ((state == ST_WRITE) && !desc);

  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(wrEn && rdEn));

  // R3
  cmp_before_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && state == ST_WRITE) |-> $past(strb.cmpEn));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (memAddr <= LAST_ADDR));

endmodule

// File: rtl/movinv_datapath.sv
module movinv_datapath
  import movinv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 4,
  parameter int PW     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  patMode_e          modeQ,
  input  logic [PW-1:0]     passIdx,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wrData,
  output logic              errFlag,
  output logic [AW-1:0]     failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs
);

  localparam int RW    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int LANES = DATA_W / 8;

  logic [7:0]        byteBase;
  logic [DATA_W-1:0] byteWord;
  logic [DATA_W-1:0] rotWord;
  logic [DATA_W-1:0] solidWord;
  logic [DATA_W-1:0] patWord;
  logic [31:0]       rotSum;
  logic [RW-1:0]     rotPos;

  always_comb begin
    if (passIdx < PW'(8)) begin
      byteBase = 8'h01 << passIdx[2:0];
    end else if (passIdx < PW'(16)) begin
      byteBase = ~(8'h01 << passIdx[2:0]);
    end else begin
      unique case (passIdx[1:0])
        2'd0: byteBase = 8'h55;
        2'd1: byteBase = 8'hAA;
        2'd2: byteBase = 8'h33;
        default: byteBase = 8'hCC;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byteWord[g*8 +: 8] = byteBase;
  end

  assign rotSum    = 32'(passIdx) + 32'(addr);
  assign rotPos    = RW'(rotSum % 32'(DATA_W));
  assign rotWord   = {{(DATA_W-1){1'b0}}, 1'b1} << rotPos;
  assign solidWord = {DATA_W{passIdx[0]}};

  always_comb begin
    unique case (modeQ)
      PM_BYTE: patWord = byteWord;
      PM_ROT:  patWord = rotWord;
      default: patWord = solidWord;
    endcase
  end

  assign wrData = patWord ^ {DATA_W{strb.invert}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      failAddr <= '0;
      failExp  <= '0;
      failObs  <= '0;
    end else if (strb.clrErr) begin
      errFlag  <= 1'b0;
      failAddr <= '0;
      failExp  <= '0;
      failObs  <= '0;
    end else if (strb.cmpEn && !errFlag && (rdData != wrData)) begin
      errFlag  <= 1'b1;
      failAddr <= addr;
      failExp  <= wrData;
      failObs  <= rdData;
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strb.clrErr) |=> errFlag);

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strb.clrErr) |=> ($stable(failAddr) && $stable(failExp) && $stable(failObs)));

  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrErr |=> !errFlag);

endmodule

// File: rtl/movinv_bist.sv
module movinv_bist
  import movinv_pkg::*;
#(
  parameter int MEM_DEPTH = 16,
  parameter int DATA_W    = 32,
  parameter int RD_LAT    = 1,
  parameter int AW        = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] rdData,
  output logic [AW-1:0]     memAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrEn,
  output logic              rdEn,
  output logic              busy,
  output logic              done,
  output logic              errFlag,
  output logic [AW-1:0]     failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs
);

  localparam int MAXP = (DATA_W > BYTE_PASSES) ? DATA_W : BYTE_PASSES;
  localparam int PW   = $clog2(MAXP);

  dpStrobe_t     strb;
  patMode_e      modeQ;
  logic [PW-1:0] passIdx;

  movinv_ctrl #(
    .MEM_DEPTH(MEM_DEPTH), .DATA_W(DATA_W), .RD_LAT(RD_LAT), .AW(AW), .PW(PW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(mode),
    .memAddr(memAddr), .wrEn(wrEn), .rdEn(rdEn), .busy(busy), .done(done),
    .modeQ(modeQ), .passIdx(passIdx), .strb(strb)
  );

  movinv_datapath #(
    .DATA_W(DATA_W), .AW(AW), .PW(PW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .modeQ(modeQ), .passIdx(passIdx),
    .addr(memAddr), .rdData(rdData), .wrData(wrData), .errFlag(errFlag),
    .failAddr(failAddr), .failExp(failExp), .failObs(failObs)
  );

endmodule

// File: tb/movinv_bist_tb.sv
module movinv_bist_tb;

  localparam int N  = 16;
  localparam int W  = 32;
  localparam int RL = 1;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    tbMode = 2'd0;
  logic [W-1:0]  rdData = '0;
  logic [AW-1:0] memAddr;
  logic [W-1:0]  wrData;
  logic          wrEn, rdEn, busy, done, errFlag;
  logic [AW-1:0] failAddr;
  logic [W-1:0]  failExp, failObs;

  int nChecks = 0;
  int nFails  = 0;

  // fault model and monitor state
  logic          faultEn = 1'b0;
  int            faultA = 0;
  int            faultB = 0;
  logic          faultV = 1'b0;
  logic          monOn = 1'b0;
  int            curMode = 0;
  int            opK = 0;
  int            monPass = 0;
  int            opsSeen = 0;
  logic [W-1:0]  mem [N];

  always #10 clk = ~clk;

  movinv_bist #(.MEM_DEPTH(N), .DATA_W(W), .RD_LAT(RL)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(tbMode), .rdData(rdData),
    .memAddr(memAddr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .busy(busy), .done(done), .errFlag(errFlag),
    .failAddr(failAddr), .failExp(failExp), .failObs(failObs)
  );

  function automatic int passesOf(input int md);
    if (md == 1) return 20;
    if (md == 2) return W;
    return 2;
  endfunction

  function automatic logic [W-1:0] benchPat(input int md, input int p, input int a);
    logic [7:0] b;
    logic [W-1:0] r;
    if (md == 1) begin
      if (p < 8) b = 8'(1 << p);
      else if (p < 16) b = ~8'(1 << (p - 8));
      else if (p == 16) b = 8'h55;
      else if (p == 17) b = 8'hAA;
      else if (p == 18) b = 8'h33;
      else b = 8'hCC;
      for (int i = 0; i < W / 8; i++) r[i*8 +: 8] = b;
      return r;
    end
    if (md == 2) return W'(1) << ((p + a) % W);
    return (p == 0) ? '0 : '1;
  endfunction

  function automatic logic [W-1:0] storeVal(input int a, input logic [W-1:0] v);
    logic [W-1:0] r;
    r = v;
    if (faultEn && a == faultA) r[faultB] = faultV;
    return r;
  endfunction

  // expected k-th port operation of a pass
  function automatic void opExp(input int md, input int p, input int k,
                                output logic isWr, output int a, output logic [W-1:0] d);
    int j, loc;
    if (k < N) begin
      isWr = 1'b1; a = k; d = benchPat(md, p, k);
    end else begin
      j   = k - N;
      loc = (j % (2 * N)) / 2;
      isWr = (j % 2) == 1;
      if (j < 2 * N) begin
        a = loc; d = ~benchPat(md, p, loc);
      end else begin
        a = N - 1 - loc; d = benchPat(md, p, N - 1 - loc);
      end
    end
  endfunction

  function automatic void goldModel(input int md, output logic e, output int fa,
                                    output logic [W-1:0] fe, output logic [W-1:0] fo);
    logic [W-1:0] m [N];
    logic [W-1:0] pv;
    e = 1'b0; fa = 0; fe = '0; fo = '0;
    for (int p = 0; p < passesOf(md); p++) begin
      for (int a = 0; a < N; a++) m[a] = storeVal(a, benchPat(md, p, a));
      for (int a = 0; a < N; a++) begin
        pv = benchPat(md, p, a);
        if (!e && m[a] != pv) begin e = 1'b1; fa = a; fe = pv; fo = m[a]; end
        m[a] = storeVal(a, ~pv);
      end
      for (int a = N - 1; a >= 0; a--) begin
        pv = ~benchPat(md, p, a);
        if (!e && m[a] != pv) begin e = 1'b1; fa = a; fe = pv; fo = m[a]; end
        m[a] = storeVal(a, ~pv);
      end
    end
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model, one-cycle read latency
  always @(posedge clk) begin
    if (wrEn) mem[memAddr] <= storeVal(int'(memAddr), wrData);
    if (rdEn) rdData <= mem[memAddr];
  end

  // port monitor: R2 R3 R4 ordering and data
  always @(negedge clk) begin
    logic isWr;
    int a;
    logic [W-1:0] d;
    if (monOn && rstN && (wrEn || rdEn)) begin
      opExp(curMode, monPass, opK, isWr, a, d);
      chk(wrEn == isWr, "R3 op kind", 64'(wrEn), 64'(isWr));
      chk(int'(memAddr) == a, "R2 op address", 64'(memAddr), 64'(a));
      if (wrEn) chk(wrData == d, "R4 write data", 64'(wrData), 64'(d));
      opsSeen++;
      if (opK == 5 * N - 1) begin opK = 0; monPass++; end
      else opK++;
    end
  end

  task automatic runTest(input int md, input logic fEn, input int fA, input int fB,
                         input logic fV, input logic midStart);
    logic eE;
    int eA;
    logic [W-1:0] eX, eO;
    int busyCnt, np, mdEff;
    faultEn = fEn; faultA = fA; faultB = fB; faultV = fV;
    mdEff = (md == 3) ? 0 : md;
    np = passesOf(mdEff);
    goldModel(mdEff, eE, eA, eX, eO);
    curMode = mdEff; opK = 0; monPass = 0; opsSeen = 0; monOn = 1'b1;
    @(negedge clk);
    tbMode = 2'(md);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyCnt = 0;
    while (!done) begin
      if (busy) busyCnt++;
      start = (midStart && busyCnt == 40);
      @(negedge clk);
    end
    start = 1'b0;
    chk(busyCnt == np * (N + 2 * N * (2 + RL)), "R8 busy cycles", 64'(busyCnt),
        64'(np * (N + 2 * N * (2 + RL))));
    chk(!busy, "R10 busy low with done", 64'(busy), 64'(0));
    chk(opsSeen == np * 5 * N, "R2 op count (R5 R6 R7 pass count)", 64'(opsSeen), 64'(np * 5 * N));
    chk(errFlag == eE, "R9 R11 error flag", 64'(errFlag), 64'(eE));
    if (eE) begin
      chk(int'(failAddr) == eA, "R9 fail address", 64'(failAddr), 64'(eA));
      chk(failExp == eX, "R9 fail expected", 64'(failExp), 64'(eX));
      chk(failObs == eO, "R9 fail observed", 64'(failObs), 64'(eO));
    end
    if (!fEn) begin
      for (int a = 0; a < N; a++)
        chk(mem[a] == benchPat(mdEff, np - 1, a), "R4 final contents", 64'(mem[a]),
            64'(benchPat(mdEff, np - 1, a)));
    end
    @(negedge clk);
    chk(!done, "R10 done one cycle", 64'(done), 64'(0));
    monOn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !errFlag && !wrEn && !rdEn, "R1 reset state",
        {59'd0, busy, done, errFlag, wrEn, rdEn}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !wrEn && !rdEn, "R1 idle after reset", {61'd0, busy, wrEn, rdEn}, 64'd0);

    runTest(0, 1'b0, 0, 0, 1'b0, 1'b0);  // R5 solid
    runTest(1, 1'b0, 0, 0, 1'b0, 1'b0);  // R6 byte
    runTest(2, 1'b0, 0, 0, 1'b0, 1'b0);  // R7 rotate
    runTest(3, 1'b0, 0, 0, 1'b0, 1'b0);  // R5 alternate code
    runTest(1, 1'b0, 0, 0, 1'b0, 1'b1);  // R10 start while busy
    runTest(0, 1'b1, N - 1, 5, 1'b0, 1'b0);  // R9 directed top-address fault
    runTest(0, 1'b0, 0, 0, 1'b0, 1'b0);  // R11 clean after failure
    runTest(2, 1'b1, 0, 0, 1'b1, 1'b0);  // R9 fault at address 0, bit 0
    for (int i = 0; i < 6; i++) begin
      runTest(int'($urandom % 4), 1'b1, int'($urandom % N), int'($urandom % W),
              1'($urandom % 2), 1'b0);
    end
    runTest(2, 1'b0, 0, 0, 1'b0, 1'b0);  // R11 clean after random failures

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule